// File: doc/BRIEF.md
# Monotonic Protection Register for a Data EEPROM

This block guards a small data EEPROM against program and erase operations. It holds one 8-bit protection register. A control bit in that register switches protection on or off, and a size field sets how far the protected window extends upward from the lowest array address. The window covers `(size + 1) << GRAN_LOG2` bytes. On the first cycle after reset in which a load-valid input is high, the register takes its value from a configuration byte. If that byte was read with an uncorrectable double-bit fault, the register is forced to full protection instead.

Software can change the register through a simple write port, but only towards more protection. The control bit can go from off to on and never back. The size field accepts only a strictly larger value. Every incoming command is either launched with a single-cycle program/erase strobe, or refused and recorded in a sticky violation flag. The command can be a byte program, a sector erase or a whole-array erase. While the flag is set, no further command launches. Software clears the flag by writing 1 to it.

Top module: `nvm_guard`

## Requirements
- R1: From reset until the load cycle, `rd_prot` reads full protection (bit 7 = 0, all size bits = 1, bits 6..5 = 0). Bus writes in that interval have no effect.
- R2: On the load cycle without a fault, bit 7 and the size bits of `cfg_byte` are copied into the register. Bits 6..5 of `rd_prot` always read 0.
- R3: On the load cycle with `cfg_dbl_fault` high, the register becomes full protection (bit 7 = 0, all size bits = 1), whatever `cfg_byte` holds.
- R4: A write with `wr_sel` = 0 may clear bit 7 (1 to 0). Writing 1 to bit 7 while it is 0 leaves it at 0.
- R5: A write with `wr_sel` = 0 replaces the size field only when the written value is strictly greater than the current one. Otherwise the field is unchanged.
- R6: While bit 7 is 0, a program (`cmd_kind` = 0) or sector erase (`cmd_kind` = 1) is refused when `cmd_addr >> GRAN_LOG2` is at most the size field. It is accepted when that value is larger.
- R7: While bit 7 is 1, program and sector-erase commands are accepted at every address, whatever the size field holds.
- R8: A block erase (`cmd_kind` = 2) is refused while bit 7 is 0 and accepted while it is 1. `cmd_kind` = 3 is no command and has no effect.
- R9: A refused command sets `rd_viol` on the next cycle. The flag stays set until a write with `wr_sel` = 1 and `wr_data[0]` = 1. While it is set, commands produce no strobe and leave the flag unchanged.
- R10: An accepted command raises `pe_strobe` for exactly the next cycle. A refused, blocked or pre-load command never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration byte is valid (load cycle) |
| cfg_byte | input | 8 | Configuration byte from program flash |
| cfg_dbl_fault | input | 1 | Double-bit fault on the configuration read |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = protection register, 1 = violation flag |
| wr_data | input | 8 | Write data |
| rd_prot | output | 8 | Current protection register value |
| rd_viol | output | 1 | Sticky protection-violation flag |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 none |
| cmd_addr | input | SIZE_W+GRAN_LOG2 | Target byte address |
| pe_strobe | output | 1 | One-cycle program/erase launch to the array |

## Verification
The bench builds the block with `SIZE_W` = 5 and `GRAN_LOG2` = 4. This gives a 512-byte array with 16-byte steps, so a window of size 10 ends at address 175. The first free address, 176, and the top address, 511, are then easy to reach directly. With the size field at its maximum, the window covers the whole array, which makes the double-fault load testable by a command at the top address.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
    typedef enum logic [1:0] {
        CMD_PROG  = 2'd0,
        CMD_SECT  = 2'd1,
        CMD_BLOCK = 2'd2,
        CMD_NONE  = 2'd3
    } cmd_kind_e;

    localparam int REG_W   = 8;
    localparam int CTL_BIT = 7;
endpackage

// File: rtl/nvm_guard_reg.sv
module nvm_guard_reg
    import nvm_guard_pkg::*;
#(
    parameter int SIZE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [REG_W-1:0]  cfg_byte,
    input  logic              cfg_dbl_fault,
    input  logic              wr_prot,
    input  logic [REG_W-1:0]  wr_data,
    output logic              loaded,
    output logic              ctl_off,
    output logic [SIZE_W-1:0] size
);
    typedef struct packed {
        logic              loaded;
        logic              ctl;
        logic [SIZE_W-1:0] size;
    } reg_state_t;

    reg_state_t state_d, state_q;

    logic unused_bits;
    assign unused_bits = ^{cfg_byte[CTL_BIT-1:SIZE_W], wr_data[CTL_BIT-1:SIZE_W]};

    always_comb begin
        state_d = state_q;
        if (!state_q.loaded) begin
            if (cfg_valid) begin
                state_d.loaded = 1'b1;
                if (cfg_dbl_fault) begin
                    state_d.ctl  = 1'b0;
                    state_d.size = '1;
                end else begin
                    state_d.ctl  = cfg_byte[CTL_BIT];
                    state_d.size = cfg_byte[SIZE_W-1:0];
                end
            end
        end else if (wr_prot) begin
            state_d.ctl = state_q.ctl & wr_data[CTL_BIT];
            if (wr_data[SIZE_W-1:0] > state_q.size) begin
                state_d.size = wr_data[SIZE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.loaded <= 1'b0;
            state_q.ctl    <= 1'b0;
            state_q.size   <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign loaded  = state_q.loaded;
    assign ctl_off = state_q.ctl;
    assign size    = state_q.size;
endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk
    import nvm_guard_pkg::*;
#(
    parameter int SIZE_W    = 5,
    parameter int GRAN_LOG2 = 6
) (
    input  logic                        ctl_off,
    input  logic [SIZE_W-1:0]           size,
    input  logic [1:0]                  cmd_kind,
    input  logic [SIZE_W+GRAN_LOG2-1:0] cmd_addr,
    output logic                        cmd_real,
    output logic                        cmd_hit
);
    localparam int ADDR_W = SIZE_W + GRAN_LOG2;

    cmd_kind_e           kind;
    logic [SIZE_W-1:0]   step;
    logic                unused_low;

    assign kind       = cmd_kind_e'(cmd_kind);
    assign step       = cmd_addr[ADDR_W-1:GRAN_LOG2];
    assign unused_low = ^cmd_addr[GRAN_LOG2-1:0];

    always_comb begin
        cmd_real = 1'b1;
        cmd_hit  = 1'b0;
        unique case (kind)
            CMD_PROG, CMD_SECT: cmd_hit = !ctl_off && (step <= size);
            CMD_BLOCK:          cmd_hit = !ctl_off;
            default:            cmd_real = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvm_guard_flag.sv
module nvm_guard_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_go,
    input  logic cmd_hit,
    input  logic clr,
    output logic viol,
    output logic strobe
);
    typedef struct packed {
        logic viol;
        logic strobe;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.strobe = 1'b0;
        if (clr) begin
            state_d.viol = 1'b0;
        end
        if (cmd_go && !state_q.viol) begin
            if (cmd_hit) begin
                state_d.viol = 1'b1;
            end else begin
                state_d.strobe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign viol   = state_q.viol;
    assign strobe = state_q.strobe;
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
    import nvm_guard_pkg::*;
#(
    parameter int SIZE_W    = 5,
    parameter int GRAN_LOG2 = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_valid,
    input  logic [7:0]                  cfg_byte,
    input  logic                        cfg_dbl_fault,
    input  logic                        wr_en,
    input  logic                        wr_sel,
    input  logic [7:0]                  wr_data,
    output logic [7:0]                  rd_prot,
    output logic                        rd_viol,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_kind,
    input  logic [SIZE_W+GRAN_LOG2-1:0] cmd_addr,
    output logic                        pe_strobe
);
    logic              loaded;
    logic              ctl_off;
    logic [SIZE_W-1:0] size;
    logic              cmd_real;
    logic              cmd_hit;
    logic              cmd_go;
    logic              wr_prot;
    logic              clr;

    assign wr_prot = wr_en && !wr_sel;
    assign clr     = loaded && wr_en && wr_sel && wr_data[0];
    assign cmd_go  = loaded && cmd_valid && cmd_real;

    nvm_guard_reg #(.SIZE_W(SIZE_W)) u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_byte      (cfg_byte),
        .cfg_dbl_fault (cfg_dbl_fault),
        .wr_prot       (wr_prot),
        .wr_data       (wr_data),
        .loaded        (loaded),
        .ctl_off       (ctl_off),
        .size          (size)
    );

    nvm_guard_chk #(.SIZE_W(SIZE_W), .GRAN_LOG2(GRAN_LOG2)) u_chk (
        .ctl_off  (ctl_off),
        .size     (size),
        .cmd_kind (cmd_kind),
        .cmd_addr (cmd_addr),
        .cmd_real (cmd_real),
        .cmd_hit  (cmd_hit)
    );

    nvm_guard_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_go  (cmd_go),
        .cmd_hit (cmd_hit),
        .clr     (clr),
        .viol    (rd_viol),
        .strobe  (pe_strobe)
    );

    always_comb begin
        rd_prot                = '0;
        rd_prot[CTL_BIT]       = ctl_off;
        rd_prot[SIZE_W-1:0]    = size;
    end
endmodule

// File: rtl/nvm_guard_sva.sv
module nvm_guard_sva #(
    parameter int SIZE_W = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       loaded,
    input logic       clr,
    input logic       cfg_valid,
    input logic       cfg_dbl_fault,
    input logic       cmd_valid,
    input logic [7:0] rd_prot,
    input logic       rd_viol,
    input logic       pe_strobe
);
    localparam logic [7:0] FULL = 8'((1 << SIZE_W) - 1);

    // R1
    preload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> rd_prot == FULL);

    // R3
    dbl_fault_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loaded && cfg_valid && cfg_dbl_fault) |=> (loaded && rd_prot == FULL));

    // R4
    ctl_no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && $past(loaded) && !$past(rd_prot[7])) |-> !rd_prot[7]);

    // R5
    size_no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && $past(loaded)) |-> rd_prot[SIZE_W-1:0] >= $past(rd_prot[SIZE_W-1:0]));

    // R9
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_viol && !clr) |=> rd_viol);

    // R9
    viol_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_viol && cmd_valid) |=> !pe_strobe);

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_strobe |=> !pe_strobe);

    // R10
    refuse_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_viol) |-> !pe_strobe);
endmodule

bind nvm_guard nvm_guard_sva #(.SIZE_W(SIZE_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .loaded        (loaded),
    .clr           (clr),
    .cfg_valid     (cfg_valid),
    .cfg_dbl_fault (cfg_dbl_fault),
    .cmd_valid     (cmd_valid),
    .rd_prot       (rd_prot),
    .rd_viol       (rd_viol),
    .pe_strobe     (pe_strobe)
);

// File: tb/test_nvm_guard.sv
`timescale 1ns/1ps
module test_nvm_guard;
    localparam int SIZE_W    = 5;
    localparam int GRAN_LOG2 = 4;
    localparam int ADDR_W    = SIZE_W + GRAN_LOG2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_valid = 1'b0;
    logic [7:0]        cfg_byte = '0;
    logic              cfg_dbl_fault = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [7:0]        wr_data = '0;
    logic [7:0]        rd_prot;
    logic              rd_viol;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_kind = 2'd3;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              pe_strobe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the register
    bit       m_loaded;
    bit       m_ctl;
    bit [4:0] m_size;
    bit       m_viol;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    nvm_guard #(.SIZE_W(SIZE_W), .GRAN_LOG2(GRAN_LOG2)) i_nvm_guard (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
        .cfg_dbl_fault(cfg_dbl_fault), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_prot(rd_prot), .rd_viol(rd_viol),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .pe_strobe(pe_strobe)
    );

    function automatic logic [7:0] model_prot();
        return {m_ctl, 2'b00, m_size};
    endfunction

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard of {pe_strobe, rd_viol}
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({pe_strobe, rd_viol} !== e) begin
                    failures++;
                    $display("FAIL %s: actual strobe/viol=%b expected=%b", t, {pe_strobe, rd_viol}, e);
                end
            end
        end
    end

    task automatic do_reset(bit dbl, logic [7:0] cfg);
        rst_n = 1'b0;
        cfg_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_loaded = 0; m_ctl = 0; m_size = 5'h1F; m_viol = 0;
        @(negedge clk);
        chk8("R1 preload value", rd_prot, 8'h1F);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0;
        chk8("R1 preload write ignored", rd_prot, 8'h1F);
        cfg_valid = 1'b1; cfg_byte = cfg; cfg_dbl_fault = dbl;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_dbl_fault = 1'b0;
        m_loaded = 1;
        if (dbl) begin m_ctl = 0; m_size = 5'h1F; end
        else begin m_ctl = cfg[7]; m_size = cfg[4:0]; end
        chk8(dbl ? "R3 fault load" : "R2 clean load", rd_prot, model_prot());
        cfg_byte = 8'hFF;
        @(negedge clk);
        chk8("R2 no second load", rd_prot, model_prot());
    endtask

    task automatic wr_prot(logic [7:0] d, string tag);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_ctl = m_ctl & d[7];
        if (d[4:0] > m_size) m_size = d[4:0];
        chk8(tag, rd_prot, model_prot());
    endtask

    task automatic clear_flag();
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        m_viol = 0;
        chk8("R9 flag cleared", {7'd0, rd_viol}, 8'd0);
    endtask

    task automatic do_cmd(logic [1:0] kind, int addr, string tag);
        bit go, hit, stb;
        cmd_valid = 1'b1; cmd_kind = kind; cmd_addr = ADDR_W'(addr);
        go  = m_loaded && kind != 2'd3 && !m_viol;
        hit = 0;
        if (!m_ctl) begin
            if (kind == 2'd2) hit = 1;
            else if (kind != 2'd3) hit = ((addr >> GRAN_LOG2) <= m_size);
        end
        stb = go && !hit;
        if (go && hit) m_viol = 1;
        @(posedge clk);
        exp_q.push_back({stb, m_viol});
        tag_q.push_back(tag);
        exp_q.push_back({1'b0, m_viol});
        tag_q.push_back({tag, " R10 pulse ends"});
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 2'd3;
        @(negedge clk);
    endtask

    initial begin
        // load with reserved bits set: control off, size 5
        do_reset(0, 8'hE5);
        do_cmd(2'd0, 0, "R7 program low addr, control off");
        do_cmd(2'd1, 40, "R7 sector erase, control off");
        do_cmd(2'd2, 0, "R8 block erase, control off");
        do_cmd(2'd3, 0, "R8 kind 3 no effect");
        wr_prot(8'h83, "R5 smaller size ignored");
        wr_prot(8'h85, "R5 equal size ignored");
        wr_prot(8'h8A, "R5 larger size taken");
        wr_prot(8'h0A, "R4 control on");
        wr_prot(8'h8A, "R4 control stays on");
        // window 0..175
        do_cmd(2'd0, 175, "R6 program last protected addr");
        do_cmd(2'd0, 400, "R9 blocked while flag set");
        do_cmd(2'd2, 0, "R9 blocked block erase");
        clear_flag();
        do_cmd(2'd0, 176, "R6 program first free addr");
        do_cmd(2'd1, 0, "R6 sector erase in window");
        clear_flag();
        do_cmd(2'd1, 511, "R6 sector erase at top");
        do_cmd(2'd2, 300, "R8 block erase with protection");
        clear_flag();
        do_cmd(2'd3, 0, "R8 kind 3 with protection");
        wr_prot(8'h9F, "R4 R5 size max, control stays on");
        do_cmd(2'd0, 511, "R6 full window top addr");
        clear_flag();
        // fault on load
        do_reset(1, 8'h80);
        do_cmd(2'd0, 511, "R3 faulted load protects top");
        clear_flag();
        do_cmd(2'd3, 0, "R10 idle no strobe");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule